// File: doc/BRIEF.md
# Watchdog Timeout Calibration Sampler

This block measures, a single time after power-up, how long an external timing ramp needs to reach its comparator trip point, and turns that measurement into the timeout that a watchdog will use. Time is measured in base watchdog ticks, supplied as a one-cycle tick enable. The latched tick count is the floor of the ramp time divided by the tick period.

Measurement starts only once the system reset has been released. If reset comes back before the ramp trips, the partial count is discarded. A fresh measurement then starts at the next release.

The block also classifies the result:

- A ramp that trips at or below a small lower limit marks the timeout as zero. This catches an open or missing timing capacitor.
- A ramp that reaches the upper limit marks the watchdog as disabled.
- A grounded timing pin also marks the watchdog as disabled.

A valid flag follows one cycle after the result is latched. From then on, the result stays frozen until the next power-on reset.

Top module: `wdt_cal_sampler`

## Requirements
- R1: After power-on reset (`rst_n` low), `tick_count` is 0 and `wd_disabled`, `wd_zero` and `cal_valid` are all 0.
- R2: No ticks are counted while `rst_active` is 1. The clock cycle in which `rst_active` is first seen at 0 only arms the measurement. Counting starts in the following cycle.
- R3: In a measuring cycle with `ramp_trip` at 1, the result is latched with `tick_count` equal to the `tick_en` pulses seen in the earlier measuring cycles. A tick in the trip cycle itself is not counted.
- R4: If `rst_active` rises during a measurement, nothing is latched. The count restarts from zero after the next release, with the same arming cycle as in R2.
- R5: `wd_zero` is 1 when a latched, non-disabled count is less than or equal to `LO_LIMIT`; otherwise it is 0.
- R6: The running count never exceeds `HI_LIMIT`. A measuring cycle that finds the count at `HI_LIMIT` latches `tick_count` = `HI_LIMIT` with `wd_disabled` = 1, and this takes priority over a trip in the same cycle.
- R7: `pin_grounded` at 1 in a measuring cycle latches `wd_disabled` = 1 with `tick_count` = 0. This takes priority over the trip and over saturation.
- R8: The result outputs change in the cycle after the latching cycle, while `cal_valid` is still 0. `cal_valid` rises one cycle later.
- R9: Once `cal_valid` is 1, all outputs hold their values until the next power-on reset, whatever the other inputs do, including a reasserted `rst_active`.
- R10: `wd_zero` and `wd_disabled` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_en | input | 1 | One-cycle pulse per base watchdog tick |
| ramp_trip | input | 1 | Ramp comparator has tripped |
| pin_grounded | input | 1 | Timing pin detected as tied to ground |
| rst_active | input | 1 | System reset currently asserted |
| tick_count | output | CNT_W | Latched timeout in base ticks |
| wd_disabled | output | 1 | Watchdog disabled (ramp too long or pin grounded) |
| wd_zero | output | 1 | Zero timeout (ramp too short) |
| cal_valid | output | 1 | Calibration result available |

## Verification
The main measurement is driven in three ways:

- Directed ramps with a tick every cycle pin the count to the exact trip cycle.
- Sparse random tick patterns show that only real tick pulses are counted, not clock cycles.
- A tick placed in the release cycle and in the trip cycle checks that neither cycle is counted.

Boundary ramps sit on both sides of each limit:

- Trips at the lower limit and one above it tell the zero class from a normal count.
- A trip one tick before saturation, and one in the saturating cycle, separate a normal count from the disabled result.

Aborted measurements followed by a new release show that the count restarts rather than carries over. After each result is latched, reset and the ramp inputs are toggled freely to show that the result stays frozen.

// File: rtl/wdt_cal_pkg.sv
package wdt_cal_pkg;

  typedef enum logic [1:0] {
    CAL_WAIT = 2'd0,
    CAL_MEAS = 2'd1,
    CAL_DONE = 2'd2
  } cal_state_e;

  typedef struct packed {
    logic dis;
    logic zero;
  } cal_class_t;

  // Classification of a finished measurement.
  // Grounded pin or saturation -> disabled; otherwise short count -> zero.
  function automatic cal_class_t f_classify(input logic        gnd,
                                            input logic        sat,
                                            input int unsigned cnt,
                                            input int unsigned lo_lim);
    cal_class_t c;
    c.dis  = gnd | sat;
    c.zero = !(gnd | sat) && (cnt <= lo_lim);
    return c;
  endfunction

endpackage

// File: rtl/wdt_ramp_counter.sv
module wdt_ramp_counter #(
  parameter int CNT_W    = 10,
  parameter int HI_LIMIT = 700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             sat
);
  localparam logic [CNT_W-1:0] HI_CNT = CNT_W'(HI_LIMIT);

  logic [CNT_W-1:0] cnt_q;

  assign sat = (cnt_q == HI_CNT);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (step && !sat) cnt_q <= cnt_q + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HI_CNT); // R6

endmodule

// File: rtl/wdt_cal_fsm.sv
module wdt_cal_fsm
  import wdt_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_active,
  input  logic tick_en,
  input  logic ramp_trip,
  input  logic pin_grounded,
  input  logic sat,
  output logic cnt_clr,
  output logic cnt_step,
  output logic latch_evt,
  output logic abort_evt
);
  cal_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr   = 1'b1;
    cnt_step  = 1'b0;
    latch_evt = 1'b0;
    abort_evt = 1'b0;
    unique case (state_q)
      CAL_WAIT: if (!rst_active) state_d = CAL_MEAS;
      CAL_MEAS: begin
        if (rst_active) begin
          abort_evt = 1'b1;
          state_d   = CAL_WAIT;
        end else begin
          cnt_clr = 1'b0;
          if (pin_grounded || sat || ramp_trip) begin
            latch_evt = 1'b1;
            state_d   = CAL_DONE;
          end else begin
            cnt_step = tick_en;
          end
        end
      end
      CAL_DONE: state_d = CAL_DONE;
      default:  state_d = CAL_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CAL_WAIT;
    else        state_q <= state_d;
  end

  AST_ABORT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (state_q == CAL_WAIT)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_DONE) |=> (state_q == CAL_DONE)); // R9

  AST_SINGLE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> !latch_evt); // R9

endmodule

// File: rtl/wdt_cal_result.sv
module wdt_cal_result
  import wdt_cal_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LO_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_evt,
  input  logic             sat,
  input  logic             pin_grounded,
  input  logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] tick_count,
  output logic             wd_disabled,
  output logic             wd_zero,
  output logic             cal_valid
);
  logic             latched_q, valid_q;
  logic [CNT_W-1:0] cnt_q;
  cal_class_t       cls_q, cls_d;

  assign cls_d = f_classify(pin_grounded, sat, 32'(run_cnt), LO_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      valid_q   <= 1'b0;
      cnt_q     <= '0;
      cls_q     <= '0;
    end else begin
      valid_q <= latched_q;
      if (latch_evt && !latched_q) begin
        latched_q <= 1'b1;
        cls_q     <= cls_d;
        cnt_q     <= pin_grounded ? '0 : run_cnt;
      end
    end
  end

  assign tick_count  = cnt_q;
  assign wd_disabled = cls_q.dis;
  assign wd_zero     = cls_q.zero;
  assign cal_valid   = valid_q;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_zero && wd_disabled)); // R10

  AST_VALID_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> !cal_valid); // R8

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |=> (cal_valid && $stable(tick_count) && $stable(wd_disabled) && $stable(wd_zero))); // R9

  AST_SAT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && sat) |=> wd_disabled); // R6

  AST_GND_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && pin_grounded) |=> (wd_disabled && tick_count == '0)); // R7

endmodule

// File: rtl/wdt_cal_sampler.sv
module wdt_cal_sampler #(
  parameter int CNT_W    = 10,
  parameter int LO_LIMIT = 2,
  parameter int HI_LIMIT = 700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ramp_trip,
  input  logic             pin_grounded,
  input  logic             rst_active,
  output logic [CNT_W-1:0] tick_count,
  output logic             wd_disabled,
  output logic             wd_zero,
  output logic             cal_valid
);
  localparam int HI_MAX = (1 << CNT_W) - 1;

  logic             cnt_clr, cnt_step, latch_evt, abort_evt, sat;
  logic [CNT_W-1:0] run_cnt;

  initial begin
    if (HI_LIMIT > HI_MAX || LO_LIMIT >= HI_LIMIT)
      $error("wdt_cal_sampler: limits do not fit CNT_W");
  end

  wdt_cal_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_active   (rst_active),
    .tick_en      (tick_en),
    .ramp_trip    (ramp_trip),
    .pin_grounded (pin_grounded),
    .sat          (sat),
    .cnt_clr      (cnt_clr),
    .cnt_step     (cnt_step),
    .latch_evt    (latch_evt),
    .abort_evt    (abort_evt)
  );

  wdt_ramp_counter #(.CNT_W(CNT_W), .HI_LIMIT(HI_LIMIT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .step  (cnt_step),
    .cnt   (run_cnt),
    .sat   (sat)
  );

  wdt_cal_result #(.CNT_W(CNT_W), .LO_LIMIT(LO_LIMIT)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_evt    (latch_evt),
    .sat          (sat),
    .pin_grounded (pin_grounded),
    .run_cnt      (run_cnt),
    .tick_count   (tick_count),
    .wd_disabled  (wd_disabled),
    .wd_zero      (wd_zero),
    .cal_valid    (cal_valid)
  );

  AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (run_cnt == '0)); // R2

  AST_ABORT_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !cal_valid) |=> !cal_valid); // R4

endmodule

// File: tb/wdt_cal_sampler_tb.sv
module wdt_cal_sampler_tb_top;
  localparam int CW = 8;
  localparam int LO = 3;
  localparam int HI = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0, ramp_trip = 1'b0, pin_gnd = 1'b0, rst_active = 1'b1;
  logic [CW-1:0] tick_count;
  logic          wd_disabled, wd_zero, cal_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wdt_cal_sampler #(.CNT_W(CW), .LO_LIMIT(LO), .HI_LIMIT(HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ramp_trip(ramp_trip),
    .pin_grounded(pin_gnd), .rst_active(rst_active), .tick_count(tick_count),
    .wd_disabled(wd_disabled), .wd_zero(wd_zero), .cal_valid(cal_valid));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_zero(input int cnt, input bit dis);
    return !dis && (cnt <= LO);
  endfunction

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; rst_active = 1'b1; tick_en = 0; ramp_trip = 0; pin_gnd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at a negedge with rst_active high; returns at the negedge after valid rose.
  task automatic measure(input int trip_at, input int tick_pct, input bit gnd,
                         input int abort_at, input string tag);
    int  cnt = 0;
    int  i = 0;
    bit  dis = 0;
    bit  done = 0;
    int  ab = abort_at;
    rst_active = 1'b0; tick_en = 1'b1; ramp_trip = 1'b1; pin_gnd = 1'b0; // arming cycle (R2)
    @(negedge clk);
    while (!done) begin
      tick_en    = (($urandom % 100) < tick_pct);
      ramp_trip  = (i == trip_at);
      pin_gnd    = gnd;
      rst_active = (i == ab);
      if (rst_active) begin
        @(negedge clk);
        chk({"R4 no result after abort ", tag}, int'(cal_valid), 0);
        repeat (3) begin
          tick_en = $urandom; ramp_trip = $urandom;
          @(negedge clk);
        end
        rst_active = 1'b0; tick_en = 1'b1; ramp_trip = 1'b0; // new arming cycle
        @(negedge clk);
        cnt = 0; i = 0; ab = -1;
        continue;
      end
      if (gnd)                   begin dis = 1; cnt = 0; done = 1; end
      else if (cnt == HI)        begin dis = 1; done = 1; end
      else if (ramp_trip)        done = 1;
      else if (tick_en)          cnt++;
      @(negedge clk);
      i++;
    end
    tick_en = 0; ramp_trip = 0; pin_gnd = 0;
    chk({"R3/R6/R7 count ", tag}, int'(tick_count), cnt);
    chk({"R6/R7 disabled ", tag}, int'(wd_disabled), int'(dis));
    chk({"R5 zero ", tag}, int'(wd_zero), int'(exp_zero(cnt, dis)));
    chk({"R8 valid still low ", tag}, int'(cal_valid), 0);
    chk({"R10 exclusive ", tag}, int'(wd_zero && wd_disabled), 0);
    @(negedge clk);
    chk({"R8 valid high ", tag}, int'(cal_valid), 1);
  endtask

  task automatic hammer(input string tag);
    int c  = int'(tick_count);
    int d  = int'(wd_disabled);
    int z  = int'(wd_zero);
    for (int k = 0; k < 12; k++) begin
      rst_active = $urandom; tick_en = $urandom; ramp_trip = $urandom; pin_gnd = $urandom;
      @(negedge clk);
    end
    chk({"R9 frozen count ", tag}, int'(tick_count), c);
    chk({"R9 frozen flags ", tag}, int'({wd_disabled, wd_zero}), (d << 1) | z);
    chk({"R9 valid held ", tag}, int'(cal_valid), 1);
    rst_active = 1'b1; tick_en = 0; ramp_trip = 0; pin_gnd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    por();
    chk("R1 count", int'(tick_count), 0);
    chk("R1 flags", int'({wd_disabled, wd_zero}), 0);
    chk("R1 valid", int'(cal_valid), 0);
    for (int k = 0; k < 6; k++) begin
      tick_en = $urandom; ramp_trip = $urandom;
      @(negedge clk);
    end
    chk("R2 nothing latched while reset held", int'(cal_valid), 0);
    tick_en = 0; ramp_trip = 0;

    measure(20, 100, 0, -1, "trip20");         hammer("trip20");
    por(); measure(0, 100, 0, -1, "trip0");     hammer("trip0");
    por(); measure(LO, 100, 0, -1, "atLO");
    por(); measure(LO + 1, 100, 0, -1, "aboveLO");
    por(); measure(HI - 1, 100, 0, -1, "belowHI");
    por(); measure(HI, 100, 0, -1, "tripAtSat");
    por(); measure(100000, 100, 0, -1, "noTrip");  hammer("noTrip");
    por(); measure(15, 100, 1, -1, "grounded");    hammer("grounded");
    por(); measure(30, 50, 0, 7, "abort7");        hammer("abort7");

    for (int r = 0; r < 25; r++) begin
      int ta  = $urandom % 90;
      int tp  = 20 + ($urandom % 81);
      bit g   = (($urandom % 8) == 0);
      int ab  = (($urandom % 4) == 0) ? int'($urandom % 40) : -1;
      por();
      measure(ta, tp, g, ab, $sformatf("rand%0d", r));
      if (r % 5 == 0) hammer($sformatf("rand%0d", r));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule